// File: doc/BRIEF.md
# Leveled Maskable Interrupt Controller

This block gathers a set of interrupt sources and decides whether a maskable request goes to the processor. Each source has its own control register. The register holds a pending flag, an enable bit and a two-bit level. Hardware raises the pending flag when the source's event fires. The flag drops when the processor accepts that source. Software may also rewrite the pending flag, but only while a global unlock bit in the memory control register is set. Enable and level can be written at any time.

A status register holds a master enable and a two-bit acceptance threshold. A source is a candidate when all of these hold:

- the master enable is 1;
- the source's enable bit is 1;
- the source's pending flag is 1;
- the source's level is numerically below the threshold.

Among the candidates, the lowest level wins. When levels are equal, the lowest index wins. The block drives the request, the winning index and the winning level straight from its registered state.

All registers sit on a simple byte-wide register bus. A write strobe updates a register at the clock edge. Read data is combinational from the address.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, every control register, the memory control register and the status register read 0, and no request is raised.
- R2: An event pulse on a source sets that source's pending flag at the next clock edge, whether the unlock bit is 0 or 1.
- R3: An accept pulse with an in-range index clears only that source's pending flag at the next edge. If that source's event arrives in the same cycle, the flag stays 1.
- R4: A bus write to a control register updates the pending flag (bit 0) only while the unlock bit is 1. While the unlock bit is 0, bit 0 of the write is ignored, and the enable and level fields are still written.
- R5: If a software write of 0 to a pending flag and an event on the same source arrive in the same cycle, the flag ends at 1.
- R6: Control register layout: pending flag at bit 0, enable at bit 1, level at bits 7:6. Source i sits at address CTRL_BASE+i (default 0x3FE0), and the unused bits read 0.
- R7: The unlock bit is bit 2 of the memory control register at address 0x3F01. Its other bits read 0.
- R8: The status register (default 0x3F00) holds the master enable at bit 6 and the threshold at bits 5:4. While the master enable is 0, no request is raised.
- R9: A source contributes to the request only if its enable is 1, its pending flag is 1 and its level is below the threshold. A level-3 source therefore never requests while the threshold is 3.
- R10: When several sources qualify, the lowest level wins, and ties go to the lowest index. The index and level outputs show the winner, and both are 0 when there is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_SRC | Per-source event pulses |
| ack_i | input | 1 | Processor accept strobe |
| ack_idx_i | input | IDX_W | Index of the accepted source |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data for bus_addr_i |
| irq_req_o | output | 1 | Maskable request to the processor |
| irq_idx_o | output | IDX_W | Winning source index |
| irq_lvl_o | output | 2 | Winning source level |

## Verification
The hardest situations to reach are the same-cycle collisions on one pending flag. These are an event against a software clear, and an event against an accept. Each needs the bus, the event lines and the accept strobe lined up on one edge.

Directed steps set up each collision deliberately, with the unlock bit both set and clear. A long random phase then mixes events, register writes to every address and accepts of the current winner. This drives many level and tie patterns past the arbiter, and a behavioural model is compared against the design on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int LVL_W  = 2;
    localparam int DATA_W = 8;

    // bit positions inside a per-source control register
    localparam int B_PEND   = 0;
    localparam int B_EN     = 1;
    localparam int B_LVL_LO = 6;

    // bit positions inside the memory control and status registers
    localparam int B_UNLOCK = 2;
    localparam int B_MIE    = 6;
    localparam int B_THR_LO = 4;

    typedef struct packed {
        logic             pend;
        logic             en;
        logic [LVL_W-1:0] lvl;
    } src_cfg_t;
endpackage

// File: rtl/irqc_src_next.sv
module irqc_src_next
    import irqc_pkg::*;
(
    input  src_cfg_t              cur_i,
    input  logic                  wr_hit_i,
    input  logic                  unlock_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic                  evt_i,
    input  logic                  ack_hit_i,
    output src_cfg_t              nxt_o
);
    always_comb begin
        nxt_o = cur_i;
        if (wr_hit_i) begin
            nxt_o.en  = wdata_i[B_EN];
            nxt_o.lvl = wdata_i[B_LVL_LO +: LVL_W];
            if (unlock_i) begin
                nxt_o.pend = wdata_i[B_PEND];
            end
        end
        if (ack_hit_i) begin
            nxt_o.pend = 1'b0;
        end
        if (evt_i) begin
            nxt_o.pend = 1'b1;
        end
    end
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
    import irqc_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  src_cfg_t [N_SRC-1:0] src_i,
    input  logic                 mie_i,
    input  logic [LVL_W-1:0]     thr_i,
    output logic                 req_o,
    output logic [IDX_W-1:0]     idx_o,
    output logic [LVL_W-1:0]     lvl_o
);
    logic [N_SRC-1:0] qual;

    for (genvar g = 0; g < N_SRC; g++) begin : g_qual
        assign qual[g] = mie_i && src_i[g].en && src_i[g].pend && (src_i[g].lvl < thr_i);
    end

    always_comb begin
        req_o = 1'b0;
        idx_o = '0;
        lvl_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (qual[i] && (!req_o || (src_i[i].lvl < lvl_o))) begin
                req_o = 1'b1;
                idx_o = IDX_W'(i);
                lvl_o = src_i[i].lvl;
            end
        end
    end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
    import irqc_pkg::*;
#(
    parameter int              N_SRC       = 8,
    parameter int              ADDR_W      = 16,
    parameter logic [15:0]     CTRL_BASE   = 16'h3FE0,
    parameter logic [15:0]     MEMCTL_ADDR = 16'h3F01,
    parameter logic [15:0]     STATUS_ADDR = 16'h3F00,
    localparam int             IDX_W       = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SRC-1:0]     evt_i,
    input  logic                 ack_i,
    input  logic [IDX_W-1:0]     ack_idx_i,
    input  logic                 bus_wr_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [7:0]           bus_wdata_i,
    output logic [7:0]           bus_rdata_o,
    output logic                 irq_req_o,
    output logic [IDX_W-1:0]     irq_idx_o,
    output logic [1:0]           irq_lvl_o
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CTRL_BASE);
    localparam logic [ADDR_W-1:0] MEMC_A = ADDR_W'(MEMCTL_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);
    localparam logic [ADDR_W-1:0] NSRC_A = ADDR_W'(N_SRC);

    typedef struct packed {
        src_cfg_t [N_SRC-1:0] src;
        logic                 unlock;
        logic                 mie;
        logic [LVL_W-1:0]     thr;
    } state_t;

    state_t state_d, state_q;

    logic [ADDR_W-1:0] ofs;
    logic              ctrl_sel;
    logic [IDX_W-1:0]  ctrl_idx;
    logic              ack_ok;
    src_cfg_t [N_SRC-1:0] src_nxt;

    assign ofs      = bus_addr_i - BASE_A;
    assign ctrl_sel = (ofs < NSRC_A);
    assign ctrl_idx = ofs[IDX_W-1:0];
    assign ack_ok   = ack_i && (32'(ack_idx_i) < N_SRC);

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        irqc_src_next u_next (
            .cur_i     (state_q.src[g]),
            .wr_hit_i  (bus_wr_i && ctrl_sel && (ctrl_idx == IDX_W'(g))),
            .unlock_i  (state_q.unlock),
            .wdata_i   (bus_wdata_i),
            .evt_i     (evt_i[g]),
            .ack_hit_i (ack_ok && (ack_idx_i == IDX_W'(g))),
            .nxt_o     (src_nxt[g])
        );
    end

    always_comb begin
        state_d     = state_q;
        state_d.src = src_nxt;
        if (bus_wr_i && (bus_addr_i == MEMC_A)) begin
            state_d.unlock = bus_wdata_i[B_UNLOCK];
        end
        if (bus_wr_i && (bus_addr_i == STAT_A)) begin
            state_d.mie = bus_wdata_i[B_MIE];
            state_d.thr = bus_wdata_i[B_THR_LO +: LVL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (ctrl_sel) begin
            bus_rdata_o[B_PEND]              = state_q.src[ctrl_idx].pend;
            bus_rdata_o[B_EN]                = state_q.src[ctrl_idx].en;
            bus_rdata_o[B_LVL_LO +: LVL_W]   = state_q.src[ctrl_idx].lvl;
        end else if (bus_addr_i == MEMC_A) begin
            bus_rdata_o[B_UNLOCK]            = state_q.unlock;
        end else if (bus_addr_i == STAT_A) begin
            bus_rdata_o[B_MIE]               = state_q.mie;
            bus_rdata_o[B_THR_LO +: LVL_W]   = state_q.thr;
        end
    end

    irqc_pick #(.N_SRC(N_SRC)) u_pick (
        .src_i (state_q.src),
        .mie_i (state_q.mie),
        .thr_i (state_q.thr),
        .req_o (irq_req_o),
        .idx_o (irq_idx_o),
        .lvl_o (irq_lvl_o)
    );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int          N_SRC     = 8,
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] CTRL_BASE = 16'h3FE0,
    localparam int         IDX_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_SRC-1:0]     evt_i,
    input logic                 ack_i,
    input logic [IDX_W-1:0]     ack_idx_i,
    input logic                 bus_wr_i,
    input logic [ADDR_W-1:0]    bus_addr_i,
    input logic                 irq_req_o,
    input logic [IDX_W-1:0]     irq_idx_o,
    input logic [1:0]           irq_lvl_o,
    input src_cfg_t [N_SRC-1:0] src_q,
    input logic                 unlock_q,
    input logic                 mie_q,
    input logic [1:0]           thr_q
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_chk
        localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(CTRL_BASE) + ADDR_W'(g);
        logic ack_me, wr_me, qual;
        assign ack_me = ack_i && (ack_idx_i == IDX_W'(g));
        assign wr_me  = bus_wr_i && (bus_addr_i == MY_A);
        assign qual   = mie_q && src_q[g].en && src_q[g].pend && (src_q[g].lvl < thr_q);

        p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[g] |=> src_q[g].pend);

        p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_me && !evt_i[g]) |=> !src_q[g].pend);

        p_locked_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_me && !unlock_q && !evt_i[g] && !ack_me) |=> $stable(src_q[g].pend));

        p_winner_best_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_req_o && qual) |-> ((src_q[g].lvl > irq_lvl_o) ||
                                     ((src_q[g].lvl == irq_lvl_o) && (IDX_W'(g) >= irq_idx_o))));
    end

    p_mie_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mie_q |-> !irq_req_o);

    p_req_qualified_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (src_q[irq_idx_o].en && src_q[irq_idx_o].pend &&
                       (src_q[irq_idx_o].lvl < thr_q) && (irq_lvl_o == src_q[irq_idx_o].lvl)));

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req_o |-> (irq_idx_o == '0 && irq_lvl_o == '0));

    p_unlock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_i |=> $stable(unlock_q));
endmodule

bind irq_level_ctrl irqc_checker #(
    .N_SRC     (N_SRC),
    .ADDR_W    (ADDR_W),
    .CTRL_BASE (CTRL_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .ack_i      (ack_i),
    .ack_idx_i  (ack_idx_i),
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .irq_req_o  (irq_req_o),
    .irq_idx_o  (irq_idx_o),
    .irq_lvl_o  (irq_lvl_o),
    .src_q      (state_q.src),
    .unlock_q   (state_q.unlock),
    .mie_q      (state_q.mie),
    .thr_q      (state_q.thr)
);

// File: tb/sim_irq_level_ctrl.sv
`timescale 1ns/1ps
module sim_irq_level_ctrl;
    localparam int N = 8;
    localparam int IW = 3;
    localparam logic [15:0] BASE = 16'h3FE0;
    localparam logic [15:0] MEMC = 16'h3F01;
    localparam logic [15:0] STAT = 16'h3F00;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  evt = '0;
    logic          ack = 1'b0;
    logic [IW-1:0] ack_idx = '0;
    logic          wr = 1'b0;
    logic [15:0]   addr = STAT;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          req;
    logic [IW-1:0] idx;
    logic [1:0]    lvl;

    always #2 clk = ~clk;

    irq_level_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .ack_i(ack), .ack_idx_i(ack_idx),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_req_o(req), .irq_idx_o(idx), .irq_lvl_o(lvl)
    );

    // behavioural reference model
    int m_pend[N];
    int m_en[N];
    int m_lvl[N];
    int m_unlock, m_mie, m_thr;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_en[i] = 0; m_lvl[i] = 0; end
            m_unlock = 0; m_mie = 0; m_thr = 0;
        end else begin
            int old_unlock;
            old_unlock = m_unlock;
            for (int i = 0; i < N; i++) begin
                if (wr && addr == BASE + 16'(i)) begin
                    m_en[i]  = int'(wdata[1]);
                    m_lvl[i] = int'(wdata[7:6]);
                    if (old_unlock != 0) m_pend[i] = int'(wdata[0]);
                end
                if (ack && int'(ack_idx) == i) m_pend[i] = 0;
                if (evt[i]) m_pend[i] = 1;
            end
            if (wr && addr == MEMC) m_unlock = int'(wdata[2]);
            if (wr && addr == STAT) begin m_mie = int'(wdata[6]); m_thr = int'(wdata[5:4]); end
        end
    end

    function automatic int exp_read(logic [15:0] a);
        for (int i = 0; i < N; i++)
            if (a == BASE + 16'(i)) return (m_lvl[i] << 6) | (m_en[i] << 1) | m_pend[i];
        if (a == MEMC) return m_unlock << 2;
        if (a == STAT) return (m_mie << 6) | (m_thr << 4);
        return 0;
    endfunction

    int e_req, e_idx, e_lvl;
    task automatic model_winner();
        e_req = 0; e_idx = 0; e_lvl = 0;
        for (int i = 0; i < N; i++) begin
            if (m_mie != 0 && m_en[i] != 0 && m_pend[i] != 0 && m_lvl[i] < m_thr) begin
                if (e_req == 0 || m_lvl[i] < e_lvl) begin
                    e_req = 1; e_idx = i; e_lvl = m_lvl[i];
                end
            end
        end
    endtask

    task automatic compare(string tag);
        model_winner();
        checks++;
        if (int'(req) != e_req || int'(idx) != e_idx || int'(lvl) != e_lvl) begin
            fails++;
            $display("FAIL %s R9 R10 req/idx/lvl actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                     tag, req, idx, lvl, e_req, e_idx, e_lvl);
        end
        checks++;
        if (int'(rdata) != exp_read(addr)) begin
            fails++;
            $display("FAIL %s R6 R7 R8 read @%h actual=%h expected=%h",
                     tag, addr, rdata, exp_read(addr));
        end
    endtask

    // one clock: inputs were set after the previous falling edge
    task automatic cyc(string tag);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle();
        wr = 0; ack = 0; evt = '0;
    endtask

    task automatic wreg(logic [15:0] a, logic [7:0] d, string tag);
        addr = a; wdata = d; wr = 1;
        cyc(tag);
        wr = 0;
    endtask

    task automatic rd(logic [15:0] a, logic [7:0] want, string tag);
        addr = a;
        #0.5;
        checks++;
        if (rdata !== want) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, rdata, want);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc("R1 reset");
        for (int i = 0; i < N; i++) rd(BASE + 16'(i), 8'h00, "R1 ctrl zero");
        rd(MEMC, 8'h00, "R1 memctl zero");
        rd(STAT, 8'h00, "R1 status zero");
        checks++;
        if (req !== 1'b0) begin fails++; $display("FAIL R1 req actual=%b expected=0", req); end

        // R2: events set flags while locked
        evt = 8'b0000_0101; cyc("R2 event"); idle();
        rd(BASE + 16'd0, 8'h01, "R2 src0 pend");
        rd(BASE + 16'd2, 8'h01, "R2 src2 pend");

        // R4: locked write ignores bit 0 but takes enable and level
        wreg(BASE + 16'd0, 8'b1000_0010, "R4 locked write");
        rd(BASE + 16'd0, 8'b1000_0011, "R4 locked flag kept");
        wreg(BASE + 16'd1, 8'b0000_0011, "R4 locked set");
        rd(BASE + 16'd1, 8'b0000_0010, "R4 locked set ignored");

        // R7: unlock, then writes reach bit 0
        wreg(MEMC, 8'hFF, "R7 unlock");
        rd(MEMC, 8'h04, "R7 unlock readback");
        wreg(BASE + 16'd0, 8'b1000_0010, "R4 unlocked clear");
        rd(BASE + 16'd0, 8'b1000_0010, "R4 cleared");
        wreg(BASE + 16'd1, 8'b0100_0011, "R4 unlocked set");
        rd(BASE + 16'd1, 8'b0100_0011, "R4 set");

        // R5: event wins over software clear in the same cycle
        addr = BASE + 16'd3; wdata = 8'b0000_0010; wr = 1; evt = 8'b0000_1000;
        cyc("R5 collision"); idle();
        rd(BASE + 16'd3, 8'b0000_0011, "R5 hw set wins");

        // R8: master enable gate, threshold 3
        wreg(STAT, 8'b0011_0000, "R8 thr3 mie0");
        checks++;
        if (req !== 1'b0) begin fails++; $display("FAIL R8 req actual=%b expected=0", req); end
        wreg(STAT, 8'b0111_0000, "R8 mie1");
        rd(STAT, 8'b0111_0000, "R8 status readback");
        // pending+enabled: src1 lvl1, src3 lvl0 -> src3 wins
        checks++;
        if (!(req === 1'b1 && idx == 3'd3 && lvl == 2'd0)) begin
            fails++; $display("FAIL R10 lowest level actual=%b/%0d/%0d expected=1/3/0", req, idx, lvl);
        end

        // R10 tie: src5 lvl0 -> src3 still wins (lower index)
        wreg(BASE + 16'd5, 8'b0000_0011, "R10 tie setup");
        checks++;
        if (idx !== 3'd3) begin fails++; $display("FAIL R10 tie actual=%0d expected=3", idx); end

        // R3: accept src3 with a same-cycle event on src3 keeps it set
        ack = 1; ack_idx = 3'd3; evt = 8'b0000_1000; addr = BASE + 16'd3;
        cyc("R3 accept+event"); idle();
        rd(BASE + 16'd3, 8'b0000_0011, "R3 flag held by event");
        // plain accept clears only src3
        ack = 1; ack_idx = 3'd3; cyc("R3 accept"); idle();
        rd(BASE + 16'd3, 8'b0000_0010, "R3 src3 cleared");
        rd(BASE + 16'd5, 8'b0000_0011, "R3 src5 untouched");
        checks++;
        if (idx !== 3'd5) begin fails++; $display("FAIL R3 next winner actual=%0d expected=5", idx); end

        // R9: level-3 source never requests under threshold 3
        wreg(BASE + 16'd5, 8'b1100_0011, "R9 lvl3");
        wreg(BASE + 16'd1, 8'b1100_0011, "R9 lvl3 b");
        checks++;
        if (req !== 1'b0) begin fails++; $display("FAIL R9 lvl3 req actual=%b expected=0", req); end

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int k;
            idle();
            if ($urandom % 4 == 0) evt = N'($urandom) & N'($urandom);
            if ($urandom % 3 == 0) begin
                k = $urandom % (N + 2);
                wr = 1; wdata = 8'($urandom);
                addr = (k < N) ? BASE + 16'(k) : ((k == N) ? MEMC : STAT);
            end else begin
                k = $urandom % (N + 3);
                addr = (k < N) ? BASE + 16'(k) : ((k == N) ? MEMC : ((k == N + 1) ? STAT : 16'h1234));
            end
            if (req && $urandom % 2 == 0) begin ack = 1; ack_idx = idx; end
            cyc("R2 R3 R4 R5 random");
        end
        idle();
        cyc("end");
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule